// File: doc/BRIEF.md
# ADC Window Comparator Counter

This block monitors a stream of ADC conversion results and decides when enough of them satisfy a programmable limit condition. Each cycle in which the input strobe is high presents one sample. A control bit picks which of two data inputs is judged: the raw conversion result or the accumulated channel value. The chosen value is compared, as an unsigned number, against a low limit and a high limit. The comparison is made under one of three criteria: below or above the window, inside the window, or at or below the low limit.

Every sample that meets the criterion advances a running count. A miss either resets the count (consecutive mode) or leaves it alone (accumulative mode). When the count reaches a programmable 10-bit target, a sticky ready flag is raised. It stays raised until software writes the clear address, and that write also zeroes the count. All settings are held in a small write-only register file. The count and the flag are driven straight out as ports.

Top module: `adc_cmp_counter`

## Requirements
- R1: Criteria code 3'b001 counts a sample as a hit when it is strictly below the low limit or strictly above the high limit.
- R2: Criteria code 3'b010 counts a sample as a hit when it is at or above the low limit and at or below the high limit.
- R3: Criteria code 3'b100 counts a sample as a hit when it is at or below the low limit, whatever the high limit holds.
- R4: Criteria codes 3'b000, 3'b011, 3'b101, 3'b110 and 3'b111 disable comparison. Samples then leave the count unchanged and never set the ready flag.
- R5: With the mode bit 0 (consecutive), each hit raises the count by one. Each miss returns it to zero on the following clock edge.
- R6: With the mode bit 1 (accumulative), a miss leaves the count unchanged.
- R7: The ready flag is set on the clock edge on which the count reaches the effective target. The effective target is the programmed value, except that the values 0 and 1 both mean a single hit.
- R8: The count saturates at 1023 and does not wrap.
- R9: The ready flag holds until a write to the clear address. That write zeroes both count and flag, and it wins over a sample presented in the same cycle.
- R10: Source select bit 0 judges `res_data`; bit 1 judges `acc_data`.
- R11: Cycles with `smp_valid` low leave the count and the flag unchanged.
- R12: Register map:
  - Address 0 holds the criteria in data bits 2:0, the mode in bit 3 and the source select in bit 4.
  - Address 1 holds the target in bits 9:0.
  - Address 2 holds the low limit and address 3 the high limit, each in bits DATA_W-1:0.
  - Address 4 is the clear command.
  - After reset the count and the flag are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample strobe; one evaluation per high cycle |
| res_data | input | DATA_W | Immediate conversion result |
| acc_data | input | DATA_W | Accumulated channel value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | WD_W | Register write data |
| viol_cnt | output | CNT_W | Running count of hits |
| cmp_ready | output | 1 | Sticky target-reached flag |

## Verification
The assertions assume that `wr_en` and `smp_valid` are known after reset and that the write-side clear is a single-cycle request. They also assume that configuration writes and samples may share a cycle, with the old configuration applying to that sample. The bench drives every input on the falling edge and holds each strobe for exactly one clock. It changes configuration only in cycles with no sample, except for the deliberate clear-versus-sample collision. The bench releases reset well before the first stimulus, so the two-flop reset release has finished before any property is armed.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_TGT  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LO   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 3'd4;

  localparam int CTRL_MODE_BIT = 3;
  localparam int CTRL_SRC_BIT  = 4;

  localparam logic [2:0] CRIT_OFF     = 3'b000;
  localparam logic [2:0] CRIT_OUTSIDE = 3'b001;
  localparam logic [2:0] CRIT_INSIDE  = 3'b010;
  localparam logic [2:0] CRIT_LOW_LE  = 3'b100;

  typedef struct packed {
    logic [2:0] crit;
    logic       accum;
    logic       src_acc;
  } ctrl_t;

endpackage

// File: rtl/adc_cmp_rst_sync.sv
module adc_cmp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/adc_cmp_regs.sv
module adc_cmp_regs
  import adc_cmp_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 10,
  parameter int WD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WD_W-1:0]   wr_data,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  target,
  output logic [DATA_W-1:0] lim_lo,
  output logic [DATA_W-1:0] lim_hi,
  output logic              clr_req
);

  ctrl_t             ctrl_q,   ctrl_d;
  logic [CNT_W-1:0]  tgt_q,    tgt_d;
  logic [DATA_W-1:0] lo_q,     lo_d;
  logic [DATA_W-1:0] hi_q,     hi_d;
  logic              unused_wd;

  assign unused_wd = ^wr_data;

  always_comb begin
    ctrl_d = ctrl_q;
    tgt_d  = tgt_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          ctrl_d.crit    = wr_data[2:0];
          ctrl_d.accum   = wr_data[CTRL_MODE_BIT];
          ctrl_d.src_acc = wr_data[CTRL_SRC_BIT];
        end
        ADDR_TGT: tgt_d = wr_data[CNT_W-1:0];
        ADDR_LO:  lo_d  = wr_data[DATA_W-1:0];
        ADDR_HI:  hi_d  = wr_data[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tgt_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      tgt_q  <= tgt_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  assign ctrl    = ctrl_q;
  assign target  = tgt_q;
  assign lim_lo  = lo_q;
  assign lim_hi  = hi_q;
  assign clr_req = wr_en && (wr_addr == ADDR_CLR);

endmodule

// File: rtl/adc_cmp_eval.sv
module adc_cmp_eval
  import adc_cmp_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              src_acc,
  input  logic [2:0]        crit,
  input  logic [DATA_W-1:0] res_data,
  input  logic [DATA_W-1:0] acc_data,
  input  logic [DATA_W-1:0] lim_lo,
  input  logic [DATA_W-1:0] lim_hi,
  output logic              enabled,
  output logic              hit
);

  logic [DATA_W-1:0] smp;
  logic              below_lo, above_hi;

  always_comb begin
    smp      = src_acc ? acc_data : res_data;
    below_lo = smp < lim_lo;
    above_hi = smp > lim_hi;
    enabled  = 1'b0;
    hit      = 1'b0;
    case (crit)
      CRIT_OUTSIDE: begin
        enabled = 1'b1;
        hit     = below_lo || above_hi;
      end
      CRIT_INSIDE: begin
        enabled = 1'b1;
        hit     = !below_lo && !above_hi;
      end
      CRIT_LOW_LE: begin
        enabled = 1'b1;
        hit     = smp <= lim_lo;
      end
      default: begin
        enabled = 1'b0;
        hit     = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/adc_cmp_count.sv
module adc_cmp_count #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic             enabled,
  input  logic             hit,
  input  logic             accum,
  input  logic [CNT_W-1:0] target,
  input  logic             clr_req,
  output logic [CNT_W-1:0] cnt,
  output logic             ready
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d, eff_tgt;
  logic             rdy_q, rdy_d;
  logic             hit_step, miss_step;

  always_comb begin
    eff_tgt   = (target <= CNT_ONE) ? CNT_ONE : target;
    hit_step  = smp_valid && enabled && hit;
    miss_step = smp_valid && enabled && !hit;
    cnt_d     = cnt_q;
    rdy_d     = rdy_q;
    if (clr_req) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else begin
      if (hit_step) begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
      end else if (miss_step && !accum) begin
        cnt_d = '0;
      end
      if (hit_step && (cnt_d >= eff_tgt)) rdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign cnt   = cnt_q;
  assign ready = rdy_q;

  // R5
  consec_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && enabled && !hit && !accum && !clr_req) |=> (cnt == '0));

  // R6
  accum_miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && enabled && !hit && accum && !clr_req) |=> $stable(cnt));

  // R4
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !enabled && !clr_req) |=> ($stable(cnt) && $stable(ready)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !clr_req) |=> ($stable(cnt) && $stable(ready)));

  // R9
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !clr_req) |=> ready);

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> ((cnt == '0) && !ready));

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !clr_req && accum) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/adc_cmp_counter.sv
module adc_cmp_counter
  import adc_cmp_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 10,
  parameter int WD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [DATA_W-1:0] acc_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WD_W-1:0]   wr_data,
  output logic [CNT_W-1:0]  viol_cnt,
  output logic              cmp_ready
);

  logic              rst_n_sync;
  ctrl_t             ctrl;
  logic [CNT_W-1:0]  target;
  logic [DATA_W-1:0] lim_lo, lim_hi;
  logic              clr_req, enabled, hit;

  adc_cmp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  adc_cmp_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .WD_W(WD_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl    (ctrl),
    .target  (target),
    .lim_lo  (lim_lo),
    .lim_hi  (lim_hi),
    .clr_req (clr_req)
  );

  adc_cmp_eval #(.DATA_W(DATA_W)) u_eval (
    .src_acc  (ctrl.src_acc),
    .crit     (ctrl.crit),
    .res_data (res_data),
    .acc_data (acc_data),
    .lim_lo   (lim_lo),
    .lim_hi   (lim_hi),
    .enabled  (enabled),
    .hit      (hit)
  );

  adc_cmp_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .smp_valid (smp_valid),
    .enabled   (enabled),
    .hit       (hit),
    .accum     (ctrl.accum),
    .target    (target),
    .clr_req   (clr_req),
    .cnt       (viol_cnt),
    .ready     (cmp_ready)
  );

  // R4
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (ctrl.crit == 3'b011) |-> !enabled);

endmodule

// File: tb/adc_cmp_counter_test.sv
module adc_cmp_counter_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 6;
  localparam int CW = 10;
  localparam int WW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic [DW-1:0] res_data = '0;
  logic [DW-1:0] acc_data = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [WW-1:0] wr_data = '0;
  logic [CW-1:0] viol_cnt;
  logic          cmp_ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  adc_cmp_counter #(.DATA_W(DW), .CNT_W(CW), .WD_W(WW)) uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .res_data(res_data), .acc_data(acc_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .viol_cnt(viol_cnt), .cmp_ready(cmp_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = WW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int crit, input int accum, input int src);
    wr(3'd0, (src << 4) | (accum << 3) | crit);
  endtask

  task automatic clear();
    wr(3'd4, 0);
  endtask

  task automatic smp(input int r, input int a);
    @(negedge clk);
    smp_valid = 1'b1; res_data = DW'(r); acc_data = DW'(a);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  function automatic bit exp_hit(input int crit, input int s, input int lo, input int hi);
    case (crit)
      1: return (s < lo) || (s > hi);
      2: return (s >= lo) && (s <= hi);
      4: return s <= lo;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 cnt", int'(viol_cnt), 0);
    chk("R12 ready", int'(cmp_ready), 0);

    wr(3'd2, 20);
    wr(3'd3, 40);
    wr(3'd1, 1);
    // R1 R2 R3 R4 R10 sweep over criteria, sources and every sample value
    for (int src = 0; src < 2; src++) begin
      for (int crit = 0; crit < 8; crit++) begin
        cfg(crit, 0, src);
        for (int s = 0; s < 64; s++) begin
          bit h;
          clear();
          if (src == 0) smp(s, 63 - s);
          else          smp(63 - s, s);
          h = exp_hit(crit, s, 20, 40);
          chk($sformatf("R1/R2/R3/R4/R10 crit%0d src%0d s%0d cnt", crit, src, s),
              int'(viol_cnt), int'(h));
          chk($sformatf("R7 crit%0d src%0d s%0d ready", crit, src, s),
              int'(cmp_ready), int'(h));
        end
      end
    end

    // R5 consecutive mode
    wr(3'd1, 10);
    cfg(2, 0, 0);
    clear();
    smp(25, 0); smp(30, 0);
    chk("R5 two hits", int'(viol_cnt), 2);
    smp(50, 0);
    chk("R5 miss resets", int'(viol_cnt), 0);
    smp(22, 0);
    chk("R5 hit after miss", int'(viol_cnt), 1);

    // R6 accumulative mode
    cfg(2, 1, 0);
    clear();
    smp(25, 0); smp(30, 0); smp(50, 0);
    chk("R6 miss holds", int'(viol_cnt), 2);
    smp(35, 0);
    chk("R6 hit continues", int'(viol_cnt), 3);

    // R11 idle cycles with hitting data ignored
    @(negedge clk); res_data = 30;
    repeat (5) @(negedge clk);
    chk("R11 idle cnt", int'(viol_cnt), 3);
    chk("R11 idle ready", int'(cmp_ready), 0);

    // R4 reserved code
    cfg(3, 1, 0);
    smp(30, 0); smp(50, 0);
    chk("R4 reserved cnt", int'(viol_cnt), 3);
    chk("R4 reserved ready", int'(cmp_ready), 0);

    // R7 target 0 and target 3
    wr(3'd1, 0);
    cfg(2, 0, 0);
    clear();
    smp(30, 0);
    chk("R7 target0 ready", int'(cmp_ready), 1);
    wr(3'd1, 3);
    clear();
    smp(30, 0); smp(30, 0);
    chk("R7 below target", int'(cmp_ready), 0);
    smp(30, 0);
    chk("R7 at target", int'(cmp_ready), 1);

    // R9 sticky across a consecutive miss, then cleared
    smp(60, 0);
    chk("R9 miss cnt", int'(viol_cnt), 0);
    chk("R9 sticky ready", int'(cmp_ready), 1);
    clear();
    chk("R9 clear ready", int'(cmp_ready), 0);
    chk("R9 clear cnt", int'(viol_cnt), 0);
    smp(30, 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd4; smp_valid = 1'b1; res_data = 30;
    @(negedge clk);
    wr_en = 1'b0; smp_valid = 1'b0;
    chk("R9 clear wins cnt", int'(viol_cnt), 0);
    chk("R9 clear wins ready", int'(cmp_ready), 0);

    // R8 saturation with target 1023
    wr(3'd1, 1023);
    cfg(4, 1, 0);
    clear();
    for (int i = 0; i < 1022; i++) smp(5, 0);
    chk("R8 cnt 1022", int'(viol_cnt), 1022);
    chk("R7 ready before 1023", int'(cmp_ready), 0);
    smp(5, 0);
    chk("R7 ready at 1023", int'(cmp_ready), 1);
    for (int i = 0; i < 7; i++) smp(5, 0);
    chk("R8 saturated", int'(viol_cnt), 1023);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule